// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Burst Deferral

This block paces DRAM row refreshes from the system clock. A fixed divide-by-16 prescaler feeds a programmable divider whose terminal count N comes from the configuration word. Each time the divider completes a period, one row refresh becomes owed. The block counts owed refreshes and raises a request toward the memory sequencer for each one. It also presents the row address that the next refresh should use.

While the sequencer reports a burst in progress, no new request is raised. The owed refreshes are still counted, so the burst is never preempted. They are paid back one by one when the burst ends, so the time for a whole-device refresh still holds on average. If the owed count reaches its limit and another interval expires, a sticky flag records the lost refresh.

The row counter wraps at a row count that the DRAM size field selects. The sequencer owns all RAS/CAS timing. It answers each request with a one-cycle acknowledge.

Top module: `refresh_sched`

## Requirements
- R1: While reset is applied and in the first cycle after it, refresh_req_o, refresh_row_o and overflow_o are all zero.
- R2: Refresh intervals are 16 × (N + 1) clock cycles long, with N = cfg_word_i[13:8]. With no burst and nothing owed, an interval ends on edge T. The request then rises on edge T + 1.
- R3: refresh_req_o never rises on an edge where burst_active_i was high. Intervals that end during a burst still add to the owed count.
- R4: Once refresh_req_o is high, it stays high until it is acknowledged, even if a burst starts in the meantime.
- R5: An acknowledge is accepted when refresh_ack_i and refresh_req_o are both high. Each accepted acknowledge pays back one owed refresh. After a burst ends, the number of accepted acknowledges equals the number of intervals that expired.
- R6: If an interval expires on the same edge that an acknowledge is accepted, the owed count stays unchanged.
- R7: refresh_row_o advances by one on each accepted acknowledge. It wraps to 0 after row (128 << S) − 1, where S = cfg_word_i[7:6]. Code 0 gives 128 rows, 1 gives 256, 2 gives 512 and 3 gives 1024.
- R8: The owed count saturates at 15. An interval that expires at 15 without a same-edge acknowledge sets overflow_o, which then stays high until reset.
- R9: A new N takes effect only at the next interval boundary. The interval already under way finishes with the old value.
- R10: An acknowledge while refresh_req_o is low is ignored. The row does not change and nothing is paid back.

Verification
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_word_i | input | 16 | Configuration word: [13:8] divider value N, [7:6] size code |
| burst_active_i | input | 1 | High while a memory burst is running |
| refresh_ack_i | input | 1 | Sequencer has taken the pending refresh |
| refresh_req_o | output | 1 | A row refresh is requested |
| refresh_row_o | output | 10 | Row address for the requested refresh |
| overflow_o | output | 1 | Sticky: an owed refresh was lost |

## Verification
The assertions assume that the sequencer acknowledges only a request it can see. An acknowledge that arrives while the request is low must leave everything untouched. They also assume that burst_active_i and refresh_ack_i are synchronous to clk_i. The stimulus changes every input on the falling edge. The acknowledge is driven either from the sampled request or as a deliberate stray pulse. Bursts are held long enough to push the owed count to saturation, and one acknowledge is placed on the exact edge an interval expires.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    PEND_HOLD = 2'd0,
    PEND_INC  = 2'd1,
    PEND_DEC  = 2'd2
  } pend_op_e;

  // interval expiry and a same-edge accepted ack cancel out
  function automatic pend_op_e pend_op(input logic tick, input logic taken);
    case ({tick, taken})
      2'b10:   return PEND_INC;
      2'b01:   return PEND_DEC;
      default: return PEND_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int PRE_DIV = 16,
  parameter int N_W     = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  output logic           tick_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [N_W-1:0]   div_q;
  logic [N_W-1:0]   n_q;
  logic             n_vld_q;
  logic [N_W-1:0]   n_eff;
  logic             pre_last;

  assign pre_last = (pre_q == PRE_W'(PRE_DIV - 1));
  assign n_eff    = n_vld_q ? n_q : n_i;
  assign tick_o   = pre_last && (div_q == n_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      div_q   <= '0;
      n_q     <= '0;
      n_vld_q <= 1'b0;
    end else begin
      pre_q <= pre_last ? '0 : pre_q + 1'b1;
      if (pre_last) div_q <= tick_o ? '0 : div_q + 1'b1;
      // divider value captured after reset and at each interval boundary only
      if (tick_o || !n_vld_q) begin
        n_q     <= n_i;
        n_vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/refresh_pend_ctr.sv
module refresh_pend_ctr
  import refresh_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              taken_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              ovf_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend_q;
  logic              ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      case (pend_op(tick_i, taken_i))
        PEND_INC: begin
          if (pend_q == PEND_MAX) ovf_q <= 1'b1;
          else                    pend_q <= pend_q + 1'b1;
        end
        PEND_DEC: pend_q <= pend_q - 1'b1;
        default:  ;
      endcase
    end
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int ROW_BASE_LOG2 = 7,
  parameter int SIZE_W        = 2,
  parameter int ROW_W         = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              adv_i,
  output logic [ROW_W-1:0]  row_o
);
  localparam int NUM_SIZES = 1 << SIZE_W;

  logic [ROW_W-1:0] last_tbl [NUM_SIZES];
  logic [ROW_W-1:0] row_q;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_last
    assign last_tbl[g] = ROW_W'((64'd1 << (ROW_BASE_LOG2 + g)) - 64'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= (row_q >= last_tbl[size_i]) ? '0 : row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CFG_W         = 16,
  parameter int N_LSB         = 8,
  parameter int N_W           = 6,
  parameter int SIZE_LSB      = 6,
  parameter int SIZE_W        = 2,
  parameter int PRE_DIV       = 16,
  parameter int PEND_W        = 4,
  parameter int ROW_BASE_LOG2 = 7,
  localparam int ROW_W        = ROW_BASE_LOG2 + (1 << SIZE_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             burst_active_i,
  input  logic             refresh_ack_i,
  output logic             refresh_req_o,
  output logic [ROW_W-1:0] refresh_row_o,
  output logic             overflow_o
);
  localparam logic [CFG_W-1:0] USED_MASK =
    CFG_W'(((64'd1 << N_W) - 64'd1) << N_LSB) |
    CFG_W'(((64'd1 << SIZE_W) - 64'd1) << SIZE_LSB);

  logic [N_W-1:0]    cfg_n;
  logic [SIZE_W-1:0] cfg_size;
  logic              cfg_unused;
  logic              tick;
  logic              taken;
  logic              req_q;
  logic [PEND_W-1:0] pend_cnt;

  assign cfg_n      = cfg_word_i[N_LSB +: N_W];
  assign cfg_size   = cfg_word_i[SIZE_LSB +: SIZE_W];
  assign cfg_unused = ^(cfg_word_i & ~USED_MASK);

  refresh_tick_gen #(.PRE_DIV(PRE_DIV), .N_W(N_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .n_i    (cfg_n),
    .tick_o (tick)
  );

  assign taken = req_q & refresh_ack_i;

  refresh_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .taken_i (taken),
    .pend_o  (pend_cnt),
    .ovf_o   (overflow_o)
  );

  refresh_row_ctr #(
    .ROW_BASE_LOG2 (ROW_BASE_LOG2),
    .SIZE_W        (SIZE_W),
    .ROW_W         (ROW_W)
  ) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .size_i (cfg_size),
    .adv_i  (taken),
    .row_o  (refresh_row_o)
  );

  // request holds until taken; raised only outside a burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_q <= 1'b0;
    else if (req_q) req_q <= !refresh_ack_i;
    else            req_q <= (pend_cnt != '0) && !burst_active_i;
  end

  assign refresh_req_o = req_q;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int PEND_W = 4,
  parameter int ROW_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              burst_active_i,
  input logic              refresh_ack_i,
  input logic              refresh_req_o,
  input logic [ROW_W-1:0]  refresh_row_o,
  input logic              overflow_o,
  input logic              tick,
  input logic [PEND_W-1:0] pend_cnt
);
  // R3
  no_rise_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refresh_req_o) |-> !$past(burst_active_i));

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_req_o && !refresh_ack_i) |=> refresh_req_o);

  // R5
  req_owed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |-> (pend_cnt != '0));

  // R6
  tick_ack_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && refresh_req_o && refresh_ack_i) |=> $stable(pend_cnt));

  // R10
  row_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refresh_req_o && refresh_ack_i) |=> $stable(refresh_row_o));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

bind refresh_sched refresh_sched_chk #(.PEND_W(PEND_W), .ROW_W(ROW_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .burst_active_i (burst_active_i),
  .refresh_ack_i  (refresh_ack_i),
  .refresh_req_o  (refresh_req_o),
  .refresh_row_o  (refresh_row_o),
  .overflow_o     (overflow_o),
  .tick           (tick),
  .pend_cnt       (pend_cnt)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cfg_word_i = '0;
  logic        burst_active_i = 1'b0;
  logic        refresh_ack_i = 1'b0;
  logic        refresh_req_o;
  logic [9:0]  refresh_row_o;
  logic        overflow_o;

  refresh_sched u_refresh_sched (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_word_i     (cfg_word_i),
    .burst_active_i (burst_active_i),
    .refresh_ack_i  (refresh_ack_i),
    .refresh_req_o  (refresh_req_o),
    .refresh_row_o  (refresh_row_o),
    .overflow_o     (overflow_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  int m_cd, m_pend, m_row, m_ticks, m_acks, m_coll;
  bit m_req, m_ovf;
  bit auto_ack = 1'b0, man_ack = 1'b0;

  function automatic int n_of();   return int'(cfg_word_i[13:8]); endfunction
  function automatic int rows_of(); return 128 << cfg_word_i[7:6]; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_cd = 16 * (n_of() + 1);
    m_pend = 0; m_row = 0; m_req = 0; m_ovf = 0;
  endtask

  // one clock: compare, drive, advance model
  task automatic step();
    bit tick, acc, nreq;
    chk(refresh_req_o == m_req, "R3/R4 model req", int'(refresh_req_o), int'(m_req));
    chk(int'(refresh_row_o) == m_row, "R7 model row", int'(refresh_row_o), m_row);
    chk(overflow_o == m_ovf, "R8 model ovf", int'(overflow_o), int'(m_ovf));
    refresh_ack_i = auto_ack ? refresh_req_o : man_ack;
    @(posedge clk_i);
    acc  = refresh_ack_i && m_req;
    m_cd--;
    tick = (m_cd == 0);
    if (tick) begin
      m_cd = 16 * (n_of() + 1);
      m_ticks++;
    end
    nreq = m_req ? !refresh_ack_i : (m_pend != 0 && !burst_active_i);
    if (tick && !acc) begin
      if (m_pend == 15) m_ovf = 1'b1;
      else              m_pend++;
    end else if (acc && !tick) m_pend--;
    if (acc) begin
      m_row = (m_row + 1 >= rows_of()) ? 0 : m_row + 1;
      m_acks++;
    end
    if (tick && acc) m_coll++;
    m_req = nreq;
    @(negedge clk_i);
  endtask

  initial begin
    int t0, a0, cnt, cyc, prev, r0, r1, r2, owed;
    bit seen127, ok127;
    m_ticks = 0; m_acks = 0; m_coll = 0;
    cfg_word_i = {2'b00, 6'd0, 2'd0, 6'd0};
    do_reset();

    // R1
    chk(refresh_req_o == 1'b0, "R1 req", int'(refresh_req_o), 0);
    chk(refresh_row_o == '0, "R1 row", int'(refresh_row_o), 0);
    chk(overflow_o == 1'b0, "R1 ovf", int'(overflow_o), 0);

    // R2: N=0 -> interval 16; request one edge after expiry
    repeat (16) step();
    chk(refresh_req_o == 1'b0, "R2 before", int'(refresh_req_o), 0);
    step();
    chk(refresh_req_o == 1'b1, "R2 raised", int'(refresh_req_o), 1);

    // R4: burst starting while requested does not withdraw it
    burst_active_i = 1'b1;
    repeat (5) step();
    chk(refresh_req_o == 1'b1, "R4 held", int'(refresh_req_o), 1);
    burst_active_i = 1'b0;

    man_ack = 1'b1; step(); man_ack = 1'b0;
    chk(refresh_row_o == 10'd1, "R7 advance", int'(refresh_row_o), 1);
    chk(refresh_req_o == 1'b0, "R5 dropped", int'(refresh_req_o), 0);

    // R10: stray ack ignored
    man_ack = 1'b1; step(); man_ack = 1'b0;
    step();
    chk(refresh_row_o == 10'd1, "R10 row kept", int'(refresh_row_o), 1);
    chk(refresh_req_o == 1'b0, "R10 nothing paid", int'(refresh_req_o), 0);

    // R3 / R5: defer through burst, repay afterwards
    t0 = m_ticks; a0 = m_acks;
    burst_active_i = 1'b1;
    step();
    cnt = 0;
    for (int i = 0; i < 80; i++) begin
      if (refresh_req_o) cnt++;
      step();
    end
    chk(cnt == 0, "R3 no req in burst", cnt, 0);
    chk(m_ticks - t0 >= 5, "R3 intervals counted", m_ticks - t0, 5);
    burst_active_i = 1'b0; auto_ack = 1'b1;
    repeat (40) step();
    chk(m_acks - a0 == m_ticks - t0, "R5 all repaid", m_acks - a0, m_ticks - t0);

    // R9: N change honoured only at the next boundary
    cfg_word_i[13:8] = 6'd3;
    cyc = 0; r0 = -1; r1 = -1; r2 = -1; prev = int'(refresh_req_o);
    for (int i = 0; i < 200; i++) begin
      step(); cyc++;
      if (refresh_req_o && prev == 0) begin
        if (r0 < 0) r0 = cyc; else if (r1 < 0) r1 = cyc; else if (r2 < 0) r2 = cyc;
      end
      prev = int'(refresh_req_o);
    end
    chk(r0 > 0 && r0 <= 17, "R9 old interval completes", r0, 17);
    chk(r1 - r0 == 64, "R9 new interval", r1 - r0, 64);
    chk(r2 - r1 == 64, "R9 new interval again", r2 - r1, 64);

    // R7: wrap points for size codes 0 and 1
    cfg_word_i[13:8] = 6'd0;
    cnt = 0;
    for (int i = 0; i < 2600 && cnt == 0; i++) begin
      prev = int'(refresh_row_o);
      step();
      if (prev == 127 && int'(refresh_row_o) != 127) begin
        cnt = 1;
        chk(refresh_row_o == '0, "R7 wrap size 0", int'(refresh_row_o), 0);
      end
    end
    chk(cnt == 1, "R7 wrap reached size 0", cnt, 1);
    cfg_word_i[7:6] = 2'd1;
    cnt = 0; seen127 = 0; ok127 = 0;
    for (int i = 0; i < 4700 && cnt == 0; i++) begin
      prev = int'(refresh_row_o);
      step();
      if (prev == 127 && int'(refresh_row_o) != 127) begin
        seen127 = 1; ok127 = (refresh_row_o == 10'd128);
      end
      if (prev == 255 && int'(refresh_row_o) != 255) begin
        cnt = 1;
        chk(refresh_row_o == '0, "R7 wrap size 1", int'(refresh_row_o), 0);
      end
    end
    chk(seen127 && ok127, "R7 no early wrap size 1", int'(ok127), 1);
    chk(cnt == 1, "R7 wrap reached size 1", cnt, 1);

    // R6: accepted ack on the expiry edge
    auto_ack = 1'b0;
    burst_active_i = 1'b1;
    repeat (40) step();
    burst_active_i = 1'b0;
    for (int i = 0; i < 4 && !refresh_req_o; i++) step();
    while (m_cd != 1) step();
    owed = m_pend;
    a0 = m_coll;
    man_ack = 1'b1; step(); man_ack = 1'b0;
    chk(m_coll - a0 == 1, "R6 collision hit", m_coll - a0, 1);
    a0 = m_acks; t0 = m_ticks;
    auto_ack = 1'b1;
    for (int i = 0; i < 12; i++) step();
    chk(m_acks - a0 == owed + (m_ticks - t0), "R6 owed unchanged", m_acks - a0, owed + (m_ticks - t0));

    // R8: saturate the owed count
    auto_ack = 1'b0;
    burst_active_i = 1'b1;
    repeat (17 * 16 + 20) step();
    chk(overflow_o == 1'b1, "R8 overflow set", int'(overflow_o), 1);
    burst_active_i = 1'b0; auto_ack = 1'b1;
    repeat (60) step();
    chk(overflow_o == 1'b1, "R8 overflow sticky", int'(overflow_o), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule